// File: doc/BRIEF.md
# Least-Recently-Used Sector Victim Selector with Sector Locking

This block keeps the recency order of every sector in an instruction cache and names the sector to evict when the cache misses on a sector. It holds a complete stack of sector indices: the top holds the most recently used sector and the bottom holds the least recently used. Each instruction fetch, and each lock or unlock command, lifts the named sector to the top in one cycle.

Sectors can be locked. A locked sector still moves through the recency order like any other sector. The victim search starts at the bottom of the stack and passes over locked sectors. When every sector is locked, the block raises a flag that reports no victim is available.

The stack and the lock bits change only while the cache-mode input is high. In program-RAM mode, every event is ignored. Victim requests are served in either mode.

Top module: `lru_sector_replacer`

## Requirements
- R1: A synchronous reset (rst_n low at a rising edge) sets the recency order to sector 0 at the top through sector 7 at the bottom. It also clears every lock bit and sets victim_sector to 0 and no_victim to 0.
- R2: In cache mode, a fetch event lifts fetch_sector to the top of the order. Entries that stood above its old place each move down by one. Entries below its old place keep their positions.
- R3: When victim_req is high at a rising edge, victim_sector and no_victim are loaded from the order and the lock bits as they stood before that edge. The new values show from that edge onward.
- R4: The victim is the unlocked sector nearest the bottom of the order. Locked sectors are skipped.
- R5: In cache mode, lock_valid sets the lock bit of cmd_sector and unlock_valid clears it. Either command also lifts cmd_sector to the top of the order. lock_mask bit i is the lock bit of sector i.
- R6: A locked sector moves to the top on a fetch, the same way an unlocked sector does.
- R7: When cache_mode is low, fetch, lock and unlock events change neither the order nor the lock bits.
- R8: A victim request made while all sectors are locked sets no_victim to 1 and leaves victim_sector at its previous value.
- R9: Without victim_req, victim_sector and no_victim hold their values.
- R10: When a lock or unlock command arrives in the same cycle as a fetch, the command's sector is lifted and the fetch is dropped. When lock_valid and unlock_valid are both high, the lock wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cache_mode | input | 1 | 1 = cache mode, 0 = program-RAM mode |
| fetch_valid | input | 1 | Instruction fetch touched a sector |
| fetch_sector | input | 3 | Sector touched by the fetch |
| lock_valid | input | 1 | Lock command |
| unlock_valid | input | 1 | Unlock command |
| cmd_sector | input | 3 | Sector named by the lock or unlock command |
| victim_req | input | 1 | Request a replacement choice |
| victim_sector | output | 3 | Chosen sector to evict |
| no_victim | output | 1 | All sectors were locked at the last request |
| lock_mask | output | 8 | Lock bit per sector |

## Verification
The recency order has no port of its own, so any corruption of it shows up only through the next victim request. Such corruption includes a lost touch, a duplicated index, or a shift applied below the touched entry. The error appears one edge after the first victim_req that reaches the damaged part of the stack. For that reason, the stimulus interleaves requests with touches, so that each stack state is probed from the bottom. A wrong lock bit appears on lock_mask one edge after the command. It also changes which sector the picker skips.

// File: rtl/lru_sr_pkg.sv
// Package: shared defaults and types for the sector replacement block.
// Assumes: the sector count is a power of two.
package lru_sr_pkg;
    localparam int DEF_SECTORS = 8;

    // Source of the stack touch in a given cycle.
    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_FETCH = 2'd1,
        SRC_CMD   = 2'd2
    } touch_src_e;
endpackage

// File: rtl/lru_recency_stack.sv
// Module: lru_recency_stack
// Holds the recency order of all sectors. Position 0 is the most recent.
// A touch lifts the given index to position 0 in one cycle. Entries above
// its old place shift down by one.
// Assumes: the stack always holds a permutation of 0..NUM_SECTORS-1.
module lru_recency_stack #(
    parameter int NUM_SECTORS = 8,
    parameter int IDX_W       = $clog2(NUM_SECTORS)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                touch_valid,
    input  logic [IDX_W-1:0]                    touch_idx,
    output logic [NUM_SECTORS-1:0][IDX_W-1:0]   order
);
    logic [NUM_SECTORS-1:0][IDX_W-1:0] order_q, order_d;
    logic [NUM_SECTORS-1:0]            hit_at;
    logic [NUM_SECTORS-1:0]            shift_at;
    logic [NUM_SECTORS-1:0]            occupied;

    // hit_at[g]: entry g holds the touched index.
    // shift_at[g]: the touched entry sits at or below g.
    for (genvar g = 0; g < NUM_SECTORS; g++) begin : g_cmp
        assign hit_at[g]   = (order_q[g] == touch_idx);
        assign shift_at[g] = |(hit_at >> g);
    end

    // Next order: the touched index goes on top, the entries above it slide down.
    always_comb begin
        order_d = order_q;
        if (touch_valid) begin
            order_d[0] = touch_idx;
            for (int i = 1; i < NUM_SECTORS; i++) begin
                if (shift_at[i]) order_d[i] = order_q[i-1];
            end
        end
    end

    // State register: reset to the order 0..N-1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SECTORS; i++) order_q[i] <= IDX_W'(i);
        end else begin
            order_q <= order_d;
        end
    end

    assign order = order_q;

    // Occupancy map, used only by the permutation check.
    always_comb begin
        occupied = '0;
        for (int i = 0; i < NUM_SECTORS; i++) occupied[order_q[i]] = 1'b1;
    end

    p_perm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(occupied) == NUM_SECTORS);
    p_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
        touch_valid |=> order_q[0] == $past(touch_idx));
    p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !touch_valid |=> $stable(order_q));
endmodule

// File: rtl/lru_lock_bank.sv
// Module: lru_lock_bank
// One lock bit per sector. A set wins over a clear when both are requested.
// Assumes: the caller gates the requests by mode.
module lru_lock_bank #(
    parameter int NUM_SECTORS = 8,
    parameter int IDX_W       = $clog2(NUM_SECTORS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   set_req,
    input  logic                   clr_req,
    input  logic [IDX_W-1:0]       idx,
    output logic [NUM_SECTORS-1:0] locked
);
    logic [NUM_SECTORS-1:0] lock_q;

    // Update the named sector's lock bit; set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= '0;
        end else if (set_req) begin
            lock_q[idx] <= 1'b1;
        end else if (clr_req) begin
            lock_q[idx] <= 1'b0;
        end
    end

    assign locked = lock_q;

    p_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        set_req |=> lock_q[$past(idx)]);
    p_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req && !set_req |=> !lock_q[$past(idx)]);
    p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !set_req && !clr_req |=> $stable(lock_q));
endmodule

// File: rtl/lru_victim_picker.sv
// Module: lru_victim_picker
// Searches the order from the bottom for the first unlocked sector. The
// result is registered on a request. When every sector is locked, the flag
// rises and the previous index is kept.
// Assumes: the order input is a permutation of the sector indices.
module lru_victim_picker #(
    parameter int NUM_SECTORS = 8,
    parameter int IDX_W       = $clog2(NUM_SECTORS)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              req,
    input  logic [NUM_SECTORS-1:0][IDX_W-1:0] order,
    input  logic [NUM_SECTORS-1:0]            locked,
    output logic [IDX_W-1:0]                  victim,
    output logic                              none_free
);
    logic [IDX_W-1:0] pick;
    logic             found;
    logic [IDX_W-1:0] victim_q;
    logic             none_q;

    // Top-down scan: the last unlocked entry seen is the one nearest the bottom.
    always_comb begin
        pick  = '0;
        found = 1'b0;
        for (int i = 0; i < NUM_SECTORS; i++) begin
            if (!locked[order[i]]) begin
                pick  = order[i];
                found = 1'b1;
            end
        end
    end

    // Result register: loads only on a request, and keeps the index when nothing is free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            victim_q <= '0;
            none_q   <= 1'b0;
        end else if (req) begin
            none_q <= !found;
            if (found) victim_q <= pick;
        end
    end

    assign victim    = victim_q;
    assign none_free = none_q;

    p_allheld_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req && (&locked) |=> none_q && $stable(victim_q));
    p_freeok_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req && !(&locked) |=> !none_q);
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> $stable(victim_q) && $stable(none_q));
endmodule

// File: rtl/lru_sector_replacer.sv
// Module: lru_sector_replacer (top)
// Gates events by mode, chooses the touch source (command over fetch),
// and connects the recency stack, the lock bits and the victim picker.
// Assumes: at most one touch per cycle reaches the stack.
module lru_sector_replacer #(
    parameter int NUM_SECTORS = lru_sr_pkg::DEF_SECTORS
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cache_mode,
    input  logic                           fetch_valid,
    input  logic [$clog2(NUM_SECTORS)-1:0] fetch_sector,
    input  logic                           lock_valid,
    input  logic                           unlock_valid,
    input  logic [$clog2(NUM_SECTORS)-1:0] cmd_sector,
    input  logic                           victim_req,
    output logic [$clog2(NUM_SECTORS)-1:0] victim_sector,
    output logic                           no_victim,
    output logic [NUM_SECTORS-1:0]         lock_mask
);
    import lru_sr_pkg::*;
    localparam int IDX_W = $clog2(NUM_SECTORS);

    touch_src_e                        src;
    logic                              touch_valid;
    logic [IDX_W-1:0]                  touch_idx;
    logic [NUM_SECTORS-1:0][IDX_W-1:0] order;
    logic                              set_req, clr_req;

    // Touch arbitration: nothing in program-RAM mode, and commands win over fetches.
    always_comb begin
        if (!cache_mode)                   src = SRC_NONE;
        else if (lock_valid || unlock_valid) src = SRC_CMD;
        else if (fetch_valid)              src = SRC_FETCH;
        else                               src = SRC_NONE;
    end

    // Index and strobe for the stack, taken from the selected source.
    always_comb begin
        touch_valid = (src != SRC_NONE);
        touch_idx   = (src == SRC_CMD) ? cmd_sector : fetch_sector;
    end

    assign set_req = cache_mode && lock_valid;
    assign clr_req = cache_mode && unlock_valid;

    lru_recency_stack #(.NUM_SECTORS(NUM_SECTORS), .IDX_W(IDX_W)) u_stack (
        .clk(clk), .rst_n(rst_n), .touch_valid(touch_valid),
        .touch_idx(touch_idx), .order(order)
    );

    lru_lock_bank #(.NUM_SECTORS(NUM_SECTORS), .IDX_W(IDX_W)) u_locks (
        .clk(clk), .rst_n(rst_n), .set_req(set_req), .clr_req(clr_req),
        .idx(cmd_sector), .locked(lock_mask)
    );

    lru_victim_picker #(.NUM_SECTORS(NUM_SECTORS), .IDX_W(IDX_W)) u_pick (
        .clk(clk), .rst_n(rst_n), .req(victim_req), .order(order),
        .locked(lock_mask), .victim(victim_sector), .none_free(no_victim)
    );

    p_pram_locks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cache_mode |=> $stable(lock_mask));
    p_cmd_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cache_mode && (lock_valid || unlock_valid) |-> touch_idx == cmd_sector);
endmodule

// File: tb/tb_lru_sector_replacer.sv
module tb_lru_sector_replacer;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 32;

    typedef struct packed {
        logic       mode;
        logic       fv;
        logic [2:0] fs;
        logic       lk;
        logic       ul;
        logic [2:0] cs;
        logic       vr;
        logic [2:0] ev;
        logic       en;
        logic [7:0] el;
    } vec_t;

    // mode fv fs lk ul cs vr | expected victim, none, lock mask
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b0,3'd0,1'b0,1'b0,3'd0,1'b1, 3'd7,1'b0,8'h00}, // 0 R1 R3
        '{1'b1,1'b1,3'd7,1'b0,1'b0,3'd0,1'b0, 3'd7,1'b0,8'h00}, // 1 R2 R9
        '{1'b1,1'b0,3'd0,1'b0,1'b0,3'd0,1'b1, 3'd6,1'b0,8'h00}, // 2 R2
        '{1'b1,1'b1,3'd3,1'b0,1'b0,3'd0,1'b1, 3'd6,1'b0,8'h00}, // 3 R3
        '{1'b1,1'b1,3'd6,1'b0,1'b0,3'd0,1'b1, 3'd6,1'b0,8'h00}, // 4 R3
        '{1'b1,1'b0,3'd0,1'b0,1'b0,3'd0,1'b1, 3'd5,1'b0,8'h00}, // 5 R2
        '{1'b1,1'b0,3'd0,1'b1,1'b0,3'd5,1'b1, 3'd5,1'b0,8'h20}, // 6 R5
        '{1'b1,1'b0,3'd0,1'b0,1'b0,3'd0,1'b1, 3'd4,1'b0,8'h20}, // 7 R5
        '{1'b1,1'b0,3'd0,1'b1,1'b0,3'd4,1'b0, 3'd4,1'b0,8'h30}, // 8 R9
        '{1'b0,1'b1,3'd2,1'b0,1'b0,3'd0,1'b1, 3'd2,1'b0,8'h30}, // 9 R7
        '{1'b0,1'b0,3'd0,1'b1,1'b0,3'd2,1'b0, 3'd2,1'b0,8'h30}, // 10 R7
        '{1'b1,1'b0,3'd0,1'b0,1'b0,3'd0,1'b1, 3'd2,1'b0,8'h30}, // 11 R7
        '{1'b1,1'b0,3'd0,1'b1,1'b0,3'd2,1'b0, 3'd2,1'b0,8'h34}, // 12 R5
        '{1'b1,1'b0,3'd0,1'b0,1'b0,3'd0,1'b1, 3'd1,1'b0,8'h34}, // 13 R4
        '{1'b1,1'b0,3'd0,1'b1,1'b0,3'd1,1'b0, 3'd1,1'b0,8'h36}, // 14
        '{1'b1,1'b1,3'd0,1'b0,1'b0,3'd0,1'b0, 3'd1,1'b0,8'h36}, // 15
        '{1'b1,1'b0,3'd0,1'b1,1'b0,3'd7,1'b0, 3'd1,1'b0,8'hB6}, // 16
        '{1'b1,1'b0,3'd0,1'b1,1'b0,3'd3,1'b0, 3'd1,1'b0,8'hBE}, // 17
        '{1'b1,1'b0,3'd0,1'b0,1'b0,3'd0,1'b1, 3'd6,1'b0,8'hBE}, // 18 R4
        '{1'b1,1'b1,3'd6,1'b0,1'b0,3'd0,1'b0, 3'd6,1'b0,8'hBE}, // 19
        '{1'b1,1'b0,3'd0,1'b0,1'b0,3'd0,1'b1, 3'd0,1'b0,8'hBE}, // 20 R4 skip
        '{1'b1,1'b1,3'd5,1'b0,1'b0,3'd0,1'b0, 3'd0,1'b0,8'hBE}, // 21 R6
        '{1'b1,1'b0,3'd0,1'b0,1'b0,3'd0,1'b1, 3'd0,1'b0,8'hBE}, // 22 R6
        '{1'b1,1'b0,3'd0,1'b1,1'b0,3'd0,1'b0, 3'd0,1'b0,8'hBF}, // 23
        '{1'b1,1'b0,3'd0,1'b1,1'b0,3'd6,1'b0, 3'd0,1'b0,8'hFF}, // 24
        '{1'b1,1'b0,3'd0,1'b0,1'b0,3'd0,1'b1, 3'd0,1'b1,8'hFF}, // 25 R8
        '{1'b1,1'b0,3'd0,1'b0,1'b1,3'd2,1'b0, 3'd0,1'b1,8'hFB}, // 26 R5 R9
        '{1'b1,1'b0,3'd0,1'b0,1'b0,3'd0,1'b1, 3'd2,1'b0,8'hFB}, // 27 R4
        '{1'b1,1'b0,3'd0,1'b0,1'b1,3'd7,1'b0, 3'd2,1'b0,8'h7B}, // 28 R5
        '{1'b1,1'b0,3'd0,1'b0,1'b0,3'd0,1'b1, 3'd2,1'b0,8'h7B}, // 29
        '{1'b1,1'b1,3'd2,1'b0,1'b0,3'd0,1'b0, 3'd2,1'b0,8'h7B}, // 30 R2
        '{1'b1,1'b0,3'd0,1'b0,1'b0,3'd0,1'b1, 3'd7,1'b0,8'h7B}  // 31 R4
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cache_mode, fetch_valid, lock_valid, unlock_valid, victim_req;
    logic [2:0] fetch_sector, cmd_sector;
    logic [2:0] victim_sector;
    logic       no_victim;
    logic [7:0] lock_mask;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lru_sector_replacer dut (
        .clk(clk), .rst_n(rst_n), .cache_mode(cache_mode),
        .fetch_valid(fetch_valid), .fetch_sector(fetch_sector),
        .lock_valid(lock_valid), .unlock_valid(unlock_valid),
        .cmd_sector(cmd_sector), .victim_req(victim_req),
        .victim_sector(victim_sector), .no_victim(no_victim),
        .lock_mask(lock_mask)
    );

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle();
        cache_mode = 1'b1; fetch_valid = 1'b0; fetch_sector = '0;
        lock_valid = 1'b0; unlock_valid = 1'b0; cmd_sector = '0;
        victim_req = 1'b0;
    endtask

    task automatic do_reset();
        idle();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        check("R1 victim", int'(victim_sector), 0);
        check("R1 none", int'(no_victim), 0);
        check("R1 locks", int'(lock_mask), 0);

        for (int v = 0; v < NV; v++) begin
            cache_mode   = VECS[v].mode;
            fetch_valid  = VECS[v].fv;
            fetch_sector = VECS[v].fs;
            lock_valid   = VECS[v].lk;
            unlock_valid = VECS[v].ul;
            cmd_sector   = VECS[v].cs;
            victim_req   = VECS[v].vr;
            @(negedge clk);
            check($sformatf("R3/R4 vec%0d victim", v), int'(victim_sector), int'(VECS[v].ev));
            check($sformatf("R8 vec%0d none", v), int'(no_victim), int'(VECS[v].en));
            check($sformatf("R5 vec%0d locks", v), int'(lock_mask), int'(VECS[v].el));
        end

        // R1: a mid-run reset restores the order and clears the locks
        do_reset();
        check("R1 reset victim", int'(victim_sector), 0);
        check("R1 reset none", int'(no_victim), 0);
        check("R1 reset locks", int'(lock_mask), 0);
        victim_req = 1'b1; @(negedge clk); idle();
        check("R1 bottom after reset", int'(victim_sector), 7);

        // R5: unlocking an unlocked sector still lifts it
        unlock_valid = 1'b1; cmd_sector = 3'd7; @(negedge clk); idle();
        check("R5 unlock keeps mask", int'(lock_mask), 0);
        victim_req = 1'b1; @(negedge clk); idle();
        check("R5 unlock lifts", int'(victim_sector), 6);

        // R10: the command beats the fetch, and lock beats unlock
        do_reset();
        fetch_valid = 1'b1; fetch_sector = 3'd7;
        lock_valid = 1'b1; unlock_valid = 1'b1; cmd_sector = 3'd6;
        @(negedge clk); idle();
        check("R10 lock wins", int'(lock_mask), 8'h40);
        victim_req = 1'b1; @(negedge clk); idle();
        check("R10 fetch dropped", int'(victim_sector), 7);

        finish_run();
    end
endmodule